// File: doc/BRIEF.md
# Periodic Reload Down-Counter Timer

This block is a 24-bit down-counting tick timer for a processor subsystem. Software programs it through four word registers: control and status, reload, current count and a read-only calibration word. Once enabled, the counter steps once per core clock or once per rising edge of an external reference tick, as a control bit selects. Each time it counts from 1 to 0 it sets a sticky flag and, if interrupts are enabled, pulses an interrupt request. The step after zero reloads the programmed value.

A reload value of N therefore gives one event every N+1 counting steps, and a reload of 0 gives no events. Reading the control word returns the flag and then clears it. Writing any value to the current-count register zeroes the counter and also clears the flag. The reference tick is brought into the core clock domain through a two-stage synchroniser and a rising-edge detector. The core clock must run at least 2.5 times faster than the reference.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current-count words all read 0.
- R2: The calibration word (index 3) reads bit 31 = reference absent, bit 30 = inexact 10 ms value, bits [23:0] = 10 ms reload value, all other bits 0. Writes to it are ignored.
- R3: Register index 0 is control, with enable at bit 0, interrupt enable at bit 1, source at bit 2 (1 = core clock, 0 = reference) and the flag at bit 16. Index 1 is reload and index 2 is the current count. Control bits other than 0..2 are not writable, and bits above bit 23 of reload and current count read as 0.
- R4: When enabled on the core clock, the counter steps from 0 to the reload value N and then counts down. The first event comes N+1 cycles after the enabling write, and later events every N+1 cycles.
- R5: With a reload of 0 no event occurs and the flag stays clear.
- R6: An event sets the flag. A read of the control word returns the flag value from before the read and clears it. Disabling the counter does not clear the flag.
- R7: If a control read and an event fall in the same cycle, the flag is left set.
- R8: A write of any value to the current-count register sets the count to 0 and clears the flag.
- R9: The interrupt request is a one-cycle pulse, issued together with the flag being set, and only when interrupt enable is 1.
- R10: With source 0 the counter steps once per synchronised rising edge of the reference tick and holds its value when no edge arrives.
- R11: Built without a reference clock, the source bit reads 1 whatever is written to it, and calibration bit 31 reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word index of the register |
| wdata_i | input | 32 | Write data |
| ref_tick_i | input | 1 | External reference tick, asynchronous |
| rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |
| irq_o | output | 1 | Tick interrupt request pulse |

## Verification
Read data is combinational and is valid in the same cycle as the read strobe. A write changes the register state at the next rising edge. The flag and the interrupt pulse appear in the cycle after the edge at which the counter goes from 1 to 0. A reference edge reaches the counter on the third core edge after it is sampled. The bench drives and samples only on falling edges. It counts falling edges from the end of each write to the expected interrupt, so the N+1 latency and period are measured exactly. It places the clearing read one cycle before the predicted event edge to test the same-cycle priority. Reference pulses are held for three cycles high and three low, so each pulse has fully propagated before the count is read.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int DATA_W   = 32;
  localparam int TENMS_W  = 24;
  localparam int BIT_EN    = 0;
  localparam int BIT_TINT  = 1;
  localparam int BIT_SRC   = 2;
  localparam int BIT_FLAG  = 16;
  localparam int BIT_SKEW  = 30;
  localparam int BIT_NOREF = 31;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_CUR    = 2'd2,
    REG_CALIB  = 2'd3
  } tick_reg_e;
endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], ref_i};
  end

  // last synchronised stage high, delayed copy low
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (step_i) begin
      if (cnt_q == '0)     cnt_q <= reload_i;
      else                 cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;
  // event is the 1 -> 0 step; a clearing write suppresses it
  assign evt_o = step_i & ~clr_i & (cnt_q == ONE);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int                 CNT_W     = 24,
  parameter bit                 HAS_REF   = 1'b1,
  parameter bit                 CAL_SKEW  = 1'b0,
  parameter logic [TENMS_W-1:0] CAL_TENMS = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              evt_i,
  output logic              en_o,
  output logic              src_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              flag_o,
  output logic              clr_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam bit SRC_RST = ~HAS_REF;

  tick_reg_e        reg_sel;
  logic             rd, wr;
  logic             en_q, tint_q, src_q, flag_q, irq_q;
  logic [CNT_W-1:0] reload_q;

  assign reg_sel = tick_reg_e'(addr_i);
  assign rd      = req_i & ~we_i;
  assign wr      = req_i & we_i;
  assign clr_o   = wr & (reg_sel == REG_CUR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      tint_q   <= 1'b0;
      src_q    <= SRC_RST;
      reload_q <= '0;
    end else if (wr) begin
      if (reg_sel == REG_CTRL) begin
        en_q   <= wdata_i[BIT_EN];
        tint_q <= wdata_i[BIT_TINT];
        src_q  <= HAS_REF ? wdata_i[BIT_SRC] : 1'b1;
      end
      if (reg_sel == REG_RELOAD) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  // set by event has priority over the read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= evt_i & tint_q;
      if (evt_i)                                 flag_q <= 1'b1;
      else if (clr_o || (rd && reg_sel == REG_CTRL)) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (reg_sel)
        REG_CTRL: begin
          rdata_o[BIT_EN]   = en_q;
          rdata_o[BIT_TINT] = tint_q;
          rdata_o[BIT_SRC]  = src_q;
          rdata_o[BIT_FLAG] = flag_q;
        end
        REG_RELOAD: rdata_o[CNT_W-1:0] = reload_q;
        REG_CUR:    rdata_o[CNT_W-1:0] = cnt_i;
        REG_CALIB: begin
          rdata_o[BIT_NOREF]     = ~HAS_REF;
          rdata_o[BIT_SKEW]      = CAL_SKEW;
          rdata_o[TENMS_W-1:0]   = CAL_TENMS;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  assign en_o     = en_q;
  assign src_o    = src_q;
  assign reload_o = reload_q;
  assign flag_o   = flag_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int                 CNT_W       = 24,
  parameter bit                 HAS_REF     = 1'b1,
  parameter int                 SYNC_STAGES = 2,
  parameter bit                 CAL_SKEW    = 1'b1,
  parameter logic [TENMS_W-1:0] CAL_TENMS   = 24'd2500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ref_tick_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             ref_rise, en_q, src_q, flag_q, clr, evt, step;
  logic [CNT_W-1:0] cnt_q, reload_q;

  generate
    if (HAS_REF) begin : g_ref
      tick_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ref_i (ref_tick_i),
        .rise_o(ref_rise)
      );
    end else begin : g_noref
      assign ref_rise = 1'b0;
    end
  endgenerate

  assign step = en_q & (src_q | ref_rise);

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .clr_i   (clr),
    .reload_i(reload_q),
    .cnt_o   (cnt_q),
    .evt_o   (evt)
  );

  tick_regs #(
    .CNT_W    (CNT_W),
    .HAS_REF  (HAS_REF),
    .CAL_SKEW (CAL_SKEW),
    .CAL_TENMS(CAL_TENMS)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_i   (cnt_q),
    .evt_i   (evt),
    .en_o    (en_q),
    .src_o   (src_q),
    .reload_o(reload_q),
    .flag_o  (flag_q),
    .clr_o   (clr),
    .irq_o   (irq_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W   = 24,
  parameter bit HAS_REF = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [31:0]      rdata_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             flag_q,
  input logic             evt,
  input logic             step,
  input logic             src_q
);
  logic rd_ctrl, wr_cur, rd_cnt;
  assign rd_ctrl = req_i & ~we_i & (addr_i == 2'd0);
  assign wr_cur  = req_i & we_i & (addr_i == 2'd2);
  assign rd_cnt  = req_i & ~we_i & (addr_i == 2'd1 || addr_i == 2'd2);

  p_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt |-> ((rdata_o >> CNT_W) == '0));
  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt_q == '0 && !wr_cur) |=> cnt_q == $past(reload_q));
  p_evt_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> (flag_q && cnt_q == '0));
  p_rdclr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl && !evt) |=> !flag_q);
  p_evt_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl && evt) |=> flag_q);
  p_wrcur_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cur |=> (cnt_q == '0 && !flag_q));
  p_irq_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_irq_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_q);
  p_src_noref_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_REF |-> src_q);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .HAS_REF(HAS_REF)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .cnt_q   (cnt_q),
  .reload_q(reload_q),
  .flag_q  (flag_q),
  .evt     (evt),
  .step    (step),
  .src_q   (src_q)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  localparam logic [23:0] TENMS = 24'd2500000;

  typedef struct packed {
    logic [23:0] rld;
    logic [2:0]  ctl;
    logic [15:0] gap;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{24'd1,  3'd7, 16'd2},
    '{24'd2,  3'd7, 16'd3},
    '{24'd5,  3'd7, 16'd6},
    '{24'd9,  3'd7, 16'd10},
    '{24'd17, 3'd7, 16'd18}
  };

  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0, ref_tick = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_nr;
  logic        irq, irq_nr;
  int n_chk = 0, n_bad = 0, irq_seen = 0;

  always #2 clk = ~clk;

  tick_timer #(.HAS_REF(1'b1), .CAL_SKEW(1'b1), .CAL_TENMS(TENMS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ref_tick_i(ref_tick), .rdata_o(rdata), .irq_o(irq));

  tick_timer #(.HAS_REF(1'b0), .CAL_SKEW(1'b1), .CAL_TENMS(TENMS)) u_dut_noref (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ref_tick_i(ref_tick), .rdata_o(rdata_nr), .irq_o(irq_nr));

  always @(negedge clk) if (irq) irq_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic [31:0] dn);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1; d = rdata; dn = rdata_nr;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < 5000);
  endtask

  task automatic ref_pulse;
    @(negedge clk); ref_tick = 1'b1;
    repeat (3) @(negedge clk);
    ref_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, dn;
    int n, m, base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 / R11 reset state
    rd(2'd0, d, dn); chk("R1 ctrl", d, 32'h0); chk("R11 noref src", dn, 32'h4);
    rd(2'd1, d, dn); chk("R1 reload", d, 32'h0);
    rd(2'd2, d, dn); chk("R1 current", d, 32'h0);
    rd(2'd3, d, dn);
    chk("R2 calib", d, {1'b0, 1'b1, 6'b0, TENMS});
    chk("R11 noref calib", dn, {1'b1, 1'b1, 6'b0, TENMS});
    wr(2'd3, 32'h0);
    rd(2'd3, d, dn); chk("R2 calib write ignored", d, {1'b0, 1'b1, 6'b0, TENMS});

    // R3 field layout
    wr(2'd0, 32'hFFFF_FFF8);
    rd(2'd0, d, dn); chk("R3 ctrl spare bits", d, 32'h0); chk("R11 src held", dn, 32'h4);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d, dn); chk("R3 reload upper zero", d, 32'h00FF_FFFF);
    wr(2'd0, 32'h7);
    rd(2'd0, d, dn); chk("R3 ctrl bits", d, 32'h7);
    wr(2'd0, 32'h0);

    // R4 / R9 table of periods on core clock
    for (int i = 0; i < 5; i++) begin
      wr(2'd0, 32'h0);
      wr(2'd1, {8'h0, VEC[i].rld});
      wr(2'd2, 32'h0);
      rd(2'd0, d, dn);
      wr(2'd0, {29'h0, VEC[i].ctl});
      wait_irq(n);
      chk("R4 first event latency", n, {16'h0, VEC[i].gap});
      @(negedge clk);
      chk("R9 irq single cycle", {31'h0, irq}, 32'h0);
      wait_irq(m);
      chk("R4 period", m + 1, {16'h0, VEC[i].gap});
    end
    wr(2'd0, 32'h0);
    rd(2'd0, d, dn);

    // R6 flag sticky, cleared by read
    wr(2'd1, 32'd3); wr(2'd2, 32'h0); wr(2'd0, 32'h7);
    wait_irq(n);
    wr(2'd0, 32'h0);
    rd(2'd0, d, dn); chk("R6 flag set", d, 32'h0001_0000);
    rd(2'd0, d, dn); chk("R6 flag cleared by read", d, 32'h0);

    // R7 event and clearing read in the same cycle
    wr(2'd1, 32'd4); wr(2'd2, 32'h0); wr(2'd0, 32'h7);
    repeat (3) @(negedge clk);
    rd(2'd0, d, dn); chk("R7 pre-event read", d, 32'h7);
    wr(2'd0, 32'h0);
    rd(2'd0, d, dn); chk("R7 flag kept", d, 32'h0001_0000);

    // R8 write to current value
    wr(2'd1, 32'd2); wr(2'd2, 32'h0); wr(2'd0, 32'h7);
    wait_irq(n);
    wr(2'd0, 32'h0);
    rd(2'd2, d, dn); chk("R4 count after reload", d, 32'd1);
    wr(2'd2, 32'h00AB_CDEF);
    rd(2'd0, d, dn); chk("R8 flag cleared by write", d, 32'h0);
    rd(2'd2, d, dn); chk("R8 count zeroed", d, 32'h0);

    // R9 no irq when interrupt enable is 0
    wr(2'd1, 32'd3); wr(2'd2, 32'h0);
    base = irq_seen;
    wr(2'd0, 32'h5);
    repeat (12) @(negedge clk);
    wr(2'd0, 32'h0);
    chk("R9 irq masked", irq_seen - base, 32'd0);
    rd(2'd0, d, dn); chk("R9 flag without irq", d, 32'h0001_0000);

    // R5 reload of zero
    wr(2'd1, 32'd0); wr(2'd2, 32'h0);
    rd(2'd0, d, dn);
    base = irq_seen;
    wr(2'd0, 32'h7);
    repeat (40) @(negedge clk);
    chk("R5 no irq", irq_seen - base, 32'd0);
    rd(2'd0, d, dn); chk("R5 no flag", d, 32'h7);
    wr(2'd0, 32'h0);

    // R10 reference tick
    wr(2'd1, 32'd2); wr(2'd2, 32'h0);
    rd(2'd0, d, dn);
    base = irq_seen;
    wr(2'd0, 32'h3);
    repeat (20) @(negedge clk);
    rd(2'd2, d, dn); chk("R10 hold without edge", d, 32'h0);
    ref_pulse();
    rd(2'd2, d, dn); chk("R10 first edge loads", d, 32'd2);
    ref_pulse();
    rd(2'd2, d, dn); chk("R10 second edge", d, 32'd1);
    ref_pulse();
    chk("R10 event irq", irq_seen - base, 32'd1);
    rd(2'd0, d, dn); chk("R10 event flag", d, 32'h0001_0003);
    wr(2'd0, 32'h0);

    summary();
    $finish;
  end
endmodule